// File: doc/BRIEF.md
# Raster-Operation Rectangle Copy Engine

This engine moves a rectangle of bytes inside a byte-addressed frame memory. Each destination byte is replaced by a boolean combination of itself and the matching source byte. The combination is one of sixteen raster operations, chosen by an 8-bit code. Software loads the geometry and the codes through a byte-wide register port, then pulses `start`. The engine latches everything it needs at that moment. It then walks the rectangle one row at a time and raises `done` for one cycle when it has finished.

For each byte the engine makes three memory requests on a single valid/ready port: a read of the source, a read of the destination, and a write of the result to the destination. A request stays on the port, unchanged, until the memory accepts it by holding `mem_ready` high at a clock edge. Read data must appear on `mem_rdata` in the cycle after the read is accepted. It must stay there until the next read is accepted.

In the forward direction, addresses climb within a row and each row start moves up by its pitch. Setting the backward bit reverses both of these. This lets a copy between overlapping regions run in whichever order keeps the source intact. An unknown operation code, or a pixel-size code outside the supported range, ends the operation at once and makes no memory request.

Top module: `blt_rop_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `mem_valid` are low until a start is accepted.
- R2: Register writes (`cfg_we`) are byte-wide, with the least significant byte at the lowest index. Source address is at 0x20..0x22 and destination address at 0x24..0x26. Source pitch is at 0x28..0x29 and destination pitch at 0x2A..0x2B. Width-minus-one is at 0x2C..0x2D and height-minus-one at 0x2E..0x2F. The mode byte is at 0x30 and the operation code at 0x32. All of these values are captured when a start is accepted, so writes made while busy affect only later operations.
- R3: Each written byte is a function of the source byte s and the destination byte d, selected by the code. The codes are: 0x00 gives 0x00; 0x05 gives s&d; 0x06 gives d (no change); 0x09 gives s&~d; 0x0B gives ~d; 0x0D gives s; 0x0E gives 0xFF; 0x50 gives ~s&d; 0x59 gives s^d; 0x6D gives s|d; 0x90 gives ~s|~d; 0x95 gives ~(s^d); 0xAD gives s|~d; 0xD0 gives ~s; 0xD6 gives ~s|d; 0xDA gives ~s&~d.
- R4: For any other code, `done` rises in the cycle after the start edge and no memory request is issued.
- R5: Mode bits [7:1] form a pixel-size code. Values 0..3 (1 to 4 bytes per pixel) run the copy. Every other value aborts exactly as in R4.
- R6: When mode bit 0 is 0, byte c of row r is read at source row start + c and written at destination row start + c. Each row start then advances by its pitch. Addresses wrap modulo 2^ADDR_W.
- R7: When mode bit 0 is 1, both pitches are subtracted from the row starts and addresses decrease within each row.
- R8: Each byte is handled as source read, then destination read, then destination write. A successful operation makes exactly 3 × (width) × (height) accepted requests.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_we` hold their values into the next cycle.
- R10: `busy` is high from the cycle after an accepted start through the single `done` cycle, and low in the cycle after that. A start that arrives while busy is ignored.
- R11: The width register holds the number of bytes per row minus one, and the height register holds the number of rows minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write byte |
| start | input | 1 | Launch strobe, taken only when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request at this edge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid from the cycle after acceptance |

## Verification
On every cycle, the embedded properties check several timing rules. A stalled request must hold steady. `done` must be a single pulse that clears `busy`. No request may appear while idle, and an aborted launch must go straight to `done` without touching memory. Every write must follow an accepted read, a no-change code must write back the byte just read, and the column counter must stay inside the row. Only the bench scenarios can show that the right bytes land at the right addresses. They cover every one of the 256 code values, forward and backward walks over overlapping and wrapping regions, random back-pressure, and registers rewritten or restarted while the engine is busy.

// File: rtl/blt_pkg.sv
package blt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WR,
    ST_FIN
  } blt_state_e;

  // register indexes (byte lanes ascend from each base)
  localparam logic [7:0] IX_SRC_ADDR  = 8'h20;
  localparam logic [7:0] IX_DST_ADDR  = 8'h24;
  localparam logic [7:0] IX_SRC_PITCH = 8'h28;
  localparam logic [7:0] IX_DST_PITCH = 8'h2A;
  localparam logic [7:0] IX_COLS_M1   = 8'h2C;
  localparam logic [7:0] IX_ROWS_M1   = 8'h2E;
  localparam logic [7:0] IX_MODE      = 8'h30;
  localparam logic [7:0] IX_ROP       = 8'h32;

  localparam int          MODE_BACK_BIT = 0;
  localparam logic [6:0]  PIXSZ_MAX     = 7'd3;

  // operation codes
  localparam logic [7:0] OP_ZERO        = 8'h00;
  localparam logic [7:0] OP_S_AND_D     = 8'h05;
  localparam logic [7:0] OP_KEEP        = 8'h06;
  localparam logic [7:0] OP_S_AND_ND    = 8'h09;
  localparam logic [7:0] OP_ND          = 8'h0B;
  localparam logic [7:0] OP_S           = 8'h0D;
  localparam logic [7:0] OP_ONES        = 8'h0E;
  localparam logic [7:0] OP_NS_AND_D    = 8'h50;
  localparam logic [7:0] OP_S_XOR_D     = 8'h59;
  localparam logic [7:0] OP_S_OR_D      = 8'h6D;
  localparam logic [7:0] OP_NS_OR_ND    = 8'h90;
  localparam logic [7:0] OP_S_XNOR_D    = 8'h95;
  localparam logic [7:0] OP_S_OR_ND     = 8'h0AD;
  localparam logic [7:0] OP_NS          = 8'hD0;
  localparam logic [7:0] OP_NS_OR_D     = 8'hD6;
  localparam logic [7:0] OP_NS_AND_ND   = 8'hDA;

endpackage

// File: rtl/blt_field.sv
module blt_field #(
  parameter int         W    = 8,
  parameter logic [7:0] BASE = 8'h20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   wr_idx,
  input  logic [7:0]   wr_data,
  output logic [W-1:0] q
);

  // one flop per bit; bit i lives in byte lane i/8 at index BASE + i/8
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [7:0] LANE_IX = BASE + 8'(i / 8);
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           bit_q <= 1'b0;
      else if (wr_en && wr_idx == LANE_IX)  bit_q <= wr_data[i % 8];
    end
    assign q[i] = bit_q;
  end

endmodule

// File: rtl/blt_rop_unit.sv
module blt_rop_unit
  import blt_pkg::*;
(
  input  logic [7:0] code,
  input  logic [7:0] src,
  input  logic [7:0] dst,
  output logic [7:0] result,
  output logic       known
);

  // truth table indexed by {src_bit, dst_bit}
  logic [3:0] tt;

  always_comb begin
    known = 1'b1;
    unique case (code)
      OP_ZERO:      tt = 4'h0;
      OP_ONES:      tt = 4'hF;
      OP_KEEP:      tt = 4'hA;
      OP_S:         tt = 4'hC;
      OP_NS:        tt = 4'h3;
      OP_ND:        tt = 4'h5;
      OP_S_AND_D:   tt = 4'h8;
      OP_S_AND_ND:  tt = 4'h4;
      OP_NS_AND_D:  tt = 4'h2;
      OP_NS_AND_ND: tt = 4'h1;
      OP_S_OR_D:    tt = 4'hE;
      OP_S_OR_ND:   tt = 4'hD;
      OP_NS_OR_D:   tt = 4'hB;
      OP_NS_OR_ND:  tt = 4'h7;
      OP_S_XOR_D:   tt = 4'h6;
      OP_S_XNOR_D:  tt = 4'h9;
      default: begin
        tt    = 4'hA;
        known = 1'b0;
      end
    endcase
  end

  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign result[b] = tt[{src[b], dst[b]}];
  end

endmodule

// File: rtl/blt_walker.sv
module blt_walker #(
  parameter int ADDR_W  = 16,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [DIM_W-1:0]  cols_m1,
  input  logic [DIM_W-1:0]  rows_m1,
  input  logic              backward,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] s_row_q, d_row_q, s_ptr_q, d_ptr_q;
  logic [ADDR_W-1:0] sp_q, dp_q;
  logic [DIM_W-1:0]  col_q, row_q, cm1_q, rm1_q;
  logic              back_q;

  logic              row_end;
  logic [ADDR_W-1:0] s_row_nx, d_row_nx, s_ptr_nx, d_ptr_nx;

  assign row_end  = (col_q == cm1_q);
  assign last     = row_end && (row_q == rm1_q);
  assign s_row_nx = back_q ? s_row_q - sp_q : s_row_q + sp_q;
  assign d_row_nx = back_q ? d_row_q - dp_q : d_row_q + dp_q;
  assign s_ptr_nx = back_q ? s_ptr_q - ONE  : s_ptr_q + ONE;
  assign d_ptr_nx = back_q ? d_ptr_q - ONE  : d_ptr_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_row_q <= '0; d_row_q <= '0; s_ptr_q <= '0; d_ptr_q <= '0;
      sp_q    <= '0; dp_q    <= '0;
      col_q   <= '0; row_q   <= '0; cm1_q   <= '0; rm1_q   <= '0;
      back_q  <= 1'b0;
    end else if (load) begin
      s_row_q <= src_base;
      d_row_q <= dst_base;
      s_ptr_q <= src_base;
      d_ptr_q <= dst_base;
      sp_q    <= ADDR_W'(src_pitch);
      dp_q    <= ADDR_W'(dst_pitch);
      cm1_q   <= cols_m1;
      rm1_q   <= rows_m1;
      col_q   <= '0;
      row_q   <= '0;
      back_q  <= backward;
    end else if (advance && !last) begin
      if (row_end) begin
        col_q   <= '0;
        row_q   <= row_q + DIM_W'(1);
        s_row_q <= s_row_nx;
        d_row_q <= d_row_nx;
        s_ptr_q <= s_row_nx;
        d_ptr_q <= d_row_nx;
      end else begin
        col_q   <= col_q + DIM_W'(1);
        s_ptr_q <= s_ptr_nx;
        d_ptr_q <= d_ptr_nx;
      end
    end
  end

  assign src_ptr = s_ptr_q;
  assign dst_ptr = d_ptr_q;

  // R6: the column position never passes the last byte of the row
  assert_col_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= cm1_q) && (row_q <= rm1_q));

endmodule

// File: rtl/blt_rop_engine.sv
module blt_rop_engine
  import blt_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  // ---------------- register bank ----------------
  logic [ADDR_W-1:0]  reg_src_addr, reg_dst_addr;
  logic [PITCH_W-1:0] reg_src_pitch, reg_dst_pitch;
  logic [DIM_W-1:0]   reg_cols_m1, reg_rows_m1;
  logic [7:0]         reg_mode, reg_rop;

  blt_field #(.W(ADDR_W),  .BASE(IX_SRC_ADDR))  u_f_saddr (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_src_addr));
  blt_field #(.W(ADDR_W),  .BASE(IX_DST_ADDR))  u_f_daddr (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_dst_addr));
  blt_field #(.W(PITCH_W), .BASE(IX_SRC_PITCH)) u_f_spitch (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_src_pitch));
  blt_field #(.W(PITCH_W), .BASE(IX_DST_PITCH)) u_f_dpitch (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_dst_pitch));
  blt_field #(.W(DIM_W),   .BASE(IX_COLS_M1))   u_f_cols (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_cols_m1));
  blt_field #(.W(DIM_W),   .BASE(IX_ROWS_M1))   u_f_rows (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_rows_m1));
  blt_field #(.W(8),       .BASE(IX_MODE))      u_f_mode (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_mode));
  blt_field #(.W(8),       .BASE(IX_ROP))       u_f_rop (.clk, .rst_n, .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .q(reg_rop));

  // ---------------- control ----------------
  blt_state_e state;
  logic [7:0] rop_q, src_q;
  logic [7:0] code_sel, rop_result;
  logic       code_known, pixsz_ok, launch, launch_ok, advance, last;
  logic [ADDR_W-1:0] src_ptr, dst_ptr;

  assign code_sel  = (state == ST_IDLE) ? reg_rop : rop_q;
  assign pixsz_ok  = (reg_mode[7:1] <= PIXSZ_MAX);
  assign launch    = start && (state == ST_IDLE);
  assign launch_ok = code_known && pixsz_ok;
  assign advance   = (state == ST_WR) && mem_ready;

  blt_rop_unit u_rop (
    .code   (code_sel),
    .src    (src_q),
    .dst    (mem_rdata),
    .result (rop_result),
    .known  (code_known)
  );

  blt_walker #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W)) u_walk (
    .clk, .rst_n,
    .load      (launch),
    .advance   (advance),
    .src_base  (reg_src_addr),
    .dst_base  (reg_dst_addr),
    .src_pitch (reg_src_pitch),
    .dst_pitch (reg_dst_pitch),
    .cols_m1   (reg_cols_m1),
    .rows_m1   (reg_rows_m1),
    .backward  (reg_mode[MODE_BACK_BIT]),
    .src_ptr   (src_ptr),
    .dst_ptr   (dst_ptr),
    .last      (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rop_q <= '0;
      src_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          rop_q <= reg_rop;
          state <= launch_ok ? ST_RD_SRC : ST_FIN;
        end
        ST_RD_SRC: if (mem_ready) state <= ST_RD_DST;
        ST_RD_DST: if (mem_ready) begin
          src_q <= mem_rdata;   // source byte still held by memory here
          state <= ST_WR;
        end
        ST_WR:  if (mem_ready) state <= last ? ST_FIN : ST_RD_SRC;
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign mem_valid = (state == ST_RD_SRC) || (state == ST_RD_DST) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_RD_SRC) ? src_ptr : dst_ptr;
  assign mem_wdata = rop_result;

  // ---------------- properties ----------------
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !done));

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !code_known) |=> (done && !mem_valid));

  assert_pixsz_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !pixsz_ok) |=> (done && !mem_valid));

  assert_keep_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && rop_q == OP_KEEP) |-> (mem_wdata == mem_rdata));

  assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !$past(mem_valid && mem_we))
      |-> $past(mem_valid && mem_ready && !mem_we));

endmodule

// File: tb/blt_rop_engine_tb.sv
module blt_rop_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_idx = '0, cfg_wdata = '0;
  logic       start = 1'b0;
  logic       busy, done, mem_valid, mem_we, mem_ready;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;   // 250 MHz

  blt_rop_engine #(.ADDR_W(8), .PITCH_W(8), .DIM_W(4)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .start, .busy, .done,
    .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
  );

  // ---------------- memory model ----------------
  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic       preload = 1'b0;
  int         seed    = 0;
  logic       bp_mode = 1'b0;
  logic [7:0] lfsr;

  function automatic logic [7:0] pat(int i, int s);
    return 8'(i * 37 + s * 11 + (i >> 3));
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) lfsr <= 8'h5A;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (preload) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
    end else if (mem_valid && mem_ready) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  assign mem_ready = !bp_mode || lfsr[0];

  // ---------------- helpers ----------------
  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // independent model of the sixteen codes; bit 8 = code known
  function automatic logic [8:0] model_rop(logic [7:0] code, logic [7:0] s, logic [7:0] d);
    case (code)
      8'h00: return {1'b1, 8'h00};
      8'h05: return {1'b1, s & d};
      8'h06: return {1'b1, d};
      8'h09: return {1'b1, s & ~d};
      8'h0B: return {1'b1, ~d};
      8'h0D: return {1'b1, s};
      8'h0E: return {1'b1, 8'hFF};
      8'h50: return {1'b1, ~s & d};
      8'h59: return {1'b1, s ^ d};
      8'h6D: return {1'b1, s | d};
      8'h90: return {1'b1, ~s | ~d};
      8'h95: return {1'b1, ~(s ^ d)};
      8'hAD: return {1'b1, s | ~d};
      8'hD0: return {1'b1, ~s};
      8'hD6: return {1'b1, ~s | d};
      8'hDA: return {1'b1, ~s & ~d};
      default: return {1'b0, d};
    endcase
  endfunction

  task automatic load_mem(input int sd);
    seed = sd;
    preload = 1'b1; tick; preload = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = pat(i, sd);
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val; tick; cfg_we = 1'b0;
  endtask

  task automatic cfg(input int sa, input int da, input int sp, input int dp,
                     input int wm1, input int hm1, input logic [7:0] mode, input logic [7:0] code);
    wr_reg(8'h20, 8'(sa)); wr_reg(8'h21, 8'h00); wr_reg(8'h22, 8'h00);
    wr_reg(8'h24, 8'(da)); wr_reg(8'h25, 8'h00); wr_reg(8'h26, 8'h00);
    wr_reg(8'h28, 8'(sp)); wr_reg(8'h29, 8'h00);
    wr_reg(8'h2A, 8'(dp)); wr_reg(8'h2B, 8'h00);
    wr_reg(8'h2C, 8'(wm1)); wr_reg(8'h2D, 8'h00);
    wr_reg(8'h2E, 8'(hm1)); wr_reg(8'h2F, 8'h00);
    wr_reg(8'h30, mode);
    wr_reg(8'h32, code);
  endtask

  // byte-serial reference of R6/R7: read src, read dst, write, in walk order
  task automatic emu(input int sa, input int da, input int sp, input int dp,
                     input int wm1, input int hm1, input bit back, input logic [7:0] code);
    int srow = sa;
    int drow = da;
    for (int r = 0; r <= hm1; r++) begin
      for (int c = 0; c <= wm1; c++) begin
        int s = back ? (srow - c) & 255 : (srow + c) & 255;
        int d = back ? (drow - c) & 255 : (drow + c) & 255;
        logic [8:0] m = model_rop(code, ref_mem[s], ref_mem[d]);
        ref_mem[d] = m[7:0];
      end
      srow = back ? (srow - sp) & 255 : (srow + sp) & 255;
      drow = back ? (drow - dp) & 255 : (drow + dp) & 255;
    end
  endtask

  task automatic check_mem(input string what);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %0d bytes differ, mem[%0d] actual %02h expected %02h",
               what, bad, first, mem[first], ref_mem[first]);
    end
  endtask

  task automatic run_op(output bit first_done, output int nacc, output bit got);
    start = 1'b1; tick; start = 1'b0;
    first_done = done;
    nacc = 0;
    got = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (done) begin got = 1'b1; break; end
      if (mem_valid && mem_ready) nacc++;
      tick;
    end
    tick;
    chk(!busy && !done, "R10 busy clears after done", busy, 0);
  endtask

  task automatic do_op(input int sa, input int da, input int sp, input int dp,
                       input int wm1, input int hm1, input logic [7:0] mode,
                       input logic [7:0] code, input int sd, input string tag);
    bit fd, got;
    int nacc;
    logic [8:0] m = model_rop(code, 8'h00, 8'h00);
    bit ok = m[8] && (mode[7:1] <= 7'd3);
    load_mem(sd);
    cfg(sa, da, sp, dp, wm1, hm1, mode, code);
    if (ok) emu(sa, da, sp, dp, wm1, hm1, mode[0], code);
    run_op(fd, nacc, got);
    chk(got, {tag, " R10 done seen"}, got, 1);
    if (!ok) begin
      chk(fd && nacc == 0, {tag, " R4/R5 abort: done next cycle, no access"}, nacc, 0);
    end else begin
      chk(nacc == 3 * (wm1 + 1) * (hm1 + 1), {tag, " R8 R11 access count"},
          nacc, 3 * (wm1 + 1) * (hm1 + 1));
    end
    check_mem({tag, " R3 R6 R7 memory image"});
  endtask

  // ---------------- watchdog ----------------
  initial begin : watchdog
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) tick;
    // R1 reset state
    chk(!busy && !done && !mem_valid, "R1 outputs low in reset", {busy, done, mem_valid}, 0);
    rst_n = 1'b1;
    tick; tick;
    chk(!busy && !done && !mem_valid, "R1 outputs low after reset", {busy, done, mem_valid}, 0);

    // R3 / R4: every code value, 3x2 rectangle, forward
    for (int code = 0; code < 256; code++) begin
      bp_mode = (code % 3 == 0);
      do_op(16, 128, 8, 16, 2, 1, 8'h00, 8'(code), code, "R3 code sweep");
    end

    // R5: pixel-size codes 0..7, both directions
    for (int pw = 0; pw < 8; pw++) begin
      for (int bk = 0; bk < 2; bk++) begin
        bp_mode = 1'(bk);
        do_op(bk ? 90 : 40, bk ? 200 : 150, 7, 9, 1, 1,
              8'((pw << 1) | bk), 8'h6D, pw + 300, "R5 pixel size");
      end
    end

    // R6 R7 R11: sizes, overlapping regions, both directions, back-pressure
    for (int bk = 0; bk < 2; bk++) begin
      for (int wm1 = 0; wm1 < 5; wm1++) begin
        for (int hm1 = 0; hm1 < 3; hm1++) begin
          bp_mode = 1'((wm1 + hm1) & 1);
          do_op(bk ? 120 : 64, bk ? 122 : 66, 6, 6, wm1, hm1, 8'(bk), 8'h0D,
                wm1 * 5 + hm1, "R6 R7 overlap copy");
          do_op(bk ? 100 : 20, bk ? 180 : 140, 11, 5, wm1, hm1, 8'(bk), 8'h59,
                wm1 + 40, "R6 R7 xor walk");
        end
      end
    end

    // R6 R7 address wrap at both ends of memory
    bp_mode = 1'b1;
    do_op(3, 250, 4, 9, 4, 2, 8'h01, 8'h95, 77, "R7 backward wrap");
    do_op(252, 1, 7, 3, 5, 2, 8'h00, 8'hAD, 78, "R6 forward wrap");

    // R2 R10: start while busy ignored; register write while busy takes effect later
    begin
      bit got;
      bp_mode = 1'b0;
      load_mem(500);
      cfg(16, 96, 8, 8, 3, 1, 8'h00, 8'h59);
      emu(16, 96, 8, 8, 3, 1, 1'b0, 8'h59);
      start = 1'b1; tick; start = 1'b0;
      chk(busy, "R10 busy after accepted start", busy, 1);
      tick;
      wr_reg(8'h32, 8'h00);           // new code during busy
      start = 1'b1; tick; start = 1'b0; // ignored
      got = 1'b0;
      for (int n = 0; n < 200; n++) begin
        if (done) begin got = 1'b1; break; end
        tick;
      end
      chk(got, "R10 first operation completes", got, 1);
      tick;
      for (int n = 0; n < 40; n++) begin
        if (busy || done || mem_valid) begin
          chk(1'b0, "R10 second start while busy was ignored", 1, 0);
          break;
        end
        tick;
      end
      chk(!busy, "R10 idle after ignored start", busy, 0);
      check_mem("R2 R10 single xor with latched code");
      // next start uses the code written during busy (constant zero)
      begin
        bit fd; int nacc;
        emu(16, 96, 8, 8, 3, 1, 1'b0, 8'h00);
        run_op(fd, nacc, got);
        chk(got && nacc == 24, "R2 later start uses new code", nacc, 24);
        check_mem("R2 zero fill after register rewrite");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule